// File: doc/BRIEF.md
# Virtual-Channel State and Credit Controller

This block holds the per-virtual-channel bookkeeping for one router input port and one output port. Each input VC steps through a five-state lifecycle: idle, routing, waiting for an output VC, active, and waiting for credits. It records the routed output port and the assigned output VC. Each output VC records whether it is owned, which input VC owns it, and how many downstream buffers are free. The block also tracks the occupancy of each input VC's flit buffer through read and write pointers, and keeps one tail marker per cell.

The routing function and both allocators are outside the block. Route results and VC grants arrive as single-cycle inputs. The block raises a switch request for each VC that is ready to send and takes switch grants back. On each grant it spends one downstream credit and returns one credit upstream. A tail flit that wins the switch frees both records at once. If another packet's head is already buffered, the input VC goes straight back to routing.

Six stall reasons are reported per input VC, each on its own output. A returning credit enters on a typed link field; it is counted only when the field carries the credit code, and the count saturates at the downstream depth.

Top module: `vc_credit_ctrl`

## Requirements
- R1: After reset all input VCs are idle (code 0), all output VCs are idle (code 0), every output-VC credit count equals CRED_MAX, no switch request is raised, the credit-out type is 2'b00 and the error flag is low.
- R2: A head flit arriving at an idle input VC moves it to routing (code 1) on the next cycle. A head flit arriving at a non-idle VC raises that VC's input-busy stall in the same cycle and leaves its state unchanged.
- R3: A route result for a VC in routing moves it to waiting-for-VC (code 2) and records the port. A route result for a VC in any other state is ignored. The routing stall is high while the state is routing.
- R4: A VC grant for an input VC in waiting-for-VC, naming an idle output VC, moves the input VC to active (code 3), or to waiting-for-credits (code 4) when that output VC has no credit. The output VC becomes active (code 1), with the owner and the assigned VC recorded. A grant naming an owned output VC is ignored, and the VC-allocation stall stays high.
- R5: A switch request is raised only for an active VC with a non-empty buffer and a nonzero credit. The buffer-empty stall is high for an active VC with an empty buffer. The switch stall is high when a request is raised without a grant.
- R6: A granted flit lowers its output VC's credit count by one on the next cycle. In that same next cycle the credit-out port shows type 2'b10 and the input VC index.
- R7: When the credit count reaches zero, the owning input VC goes to waiting-for-credits (code 4) and the output VC goes to code 2. The credit stall is high and no request is raised. A returned credit brings both back to active.
- R8: A credit-in of type 2'b10 increments the named output VC's count. Types 2'b11 (flit) and 2'b0x (idle) leave every count unchanged.
- R9: A credit returned to a count already at CRED_MAX leaves the count at CRED_MAX and raises the error flag for exactly one cycle.
- R10: A switch grant and a credit return on the same output VC in the same cycle leave its count unchanged, with no error, even at CRED_MAX.
- R11: When the tail flit is granted, the input VC goes to idle if its buffer is then empty, or to routing if flits remain. The output VC goes idle. The recorded port, output VC and owner fields return to 0. Credit counts are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flit_valid_i | input | 1 | Flit arrival strobe |
| flit_vc_i | input | VW | Input VC of the arriving flit |
| flit_head_i | input | 1 | Arriving flit is a head |
| flit_tail_i | input | 1 | Arriving flit is a tail |
| route_valid_i | input | 1 | Route result strobe |
| route_vc_i | input | VW | Input VC the route applies to |
| route_port_i | input | PW | Computed output port |
| va_valid_i | input | 1 | VC allocation grant strobe |
| va_ivc_i | input | VW | Input VC that won |
| va_ovc_i | input | VW | Output VC granted |
| sw_gnt_i | input | NUM_VC | Switch grant per input VC, at most one set |
| cred_in_type_i | input | 2 | Upstream link type code: 10 credit, 11 flit, 0x idle |
| cred_in_vc_i | input | VW | Output VC the credit belongs to |
| sw_req_o | output | NUM_VC | Switch request per input VC |
| cred_out_type_o | output | 2 | Credit-out type code (10 on a credit) |
| cred_out_vc_o | output | VW | Input VC whose slot was freed |
| ivc_state_o | output | NUM_VC*3 | Input VC states, 3 bits each |
| ivc_port_o | output | NUM_VC*PW | Recorded output port per input VC |
| ivc_ovc_o | output | NUM_VC*VW | Assigned output VC per input VC |
| ovc_state_o | output | NUM_VC*2 | Output VC states, 2 bits each |
| ovc_owner_o | output | NUM_VC*VW | Owning input VC per output VC |
| ovc_cred_o | output | NUM_VC*CW | Free downstream buffers per output VC |
| stall_busy_o | output | NUM_VC | Head arrived at a busy input VC |
| stall_route_o | output | NUM_VC | Waiting for a route |
| stall_va_o | output | NUM_VC | Waiting for an output VC |
| stall_sw_o | output | NUM_VC | Requested the switch but lost |
| stall_empty_o | output | NUM_VC | Active with an empty buffer |
| stall_cred_o | output | NUM_VC | Active but out of credits |
| cred_err_o | output | 1 | Credit overflow, one-cycle pulse |

## Verification
The bench runs packets of every length from one flit up to one flit more than the credit depth. The longest packet must park in waiting-for-credits and resume on a returned credit; a design that tested stale credits would send a flit it has no room for. Credits of the flit and idle types are sent while the count is at its cap, so a decoder that did not check the type would raise a false overflow. A grant and a credit return land together, once at the cap and once below it; a design that let the increment win would drift or flag an error. A head is parked behind an active packet and a VC grant is aimed at an owned output VC. The parked head must send the VC straight back to routing on tail release, and the grant must be refused.

// File: rtl/vc_ctrl_pkg.sv
package vc_ctrl_pkg;
  typedef enum logic [2:0] {
    IVC_IDLE      = 3'd0,
    IVC_ROUTE     = 3'd1,
    IVC_WAIT_VC   = 3'd2,
    IVC_ACTIVE    = 3'd3,
    IVC_WAIT_CRED = 3'd4
  } ivc_state_e;

  typedef enum logic [1:0] {
    OVC_IDLE      = 2'd0,
    OVC_ACTIVE    = 2'd1,
    OVC_WAIT_CRED = 2'd2
  } ovc_state_e;

  localparam logic [1:0] LINK_IDLE   = 2'b00;
  localparam logic [1:0] LINK_CREDIT = 2'b10;
  localparam logic [1:0] LINK_FLIT   = 2'b11;
endpackage

// File: rtl/vc_in_unit.sv
module vc_in_unit
  import vc_ctrl_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int NUM_PORTS = 5,
  parameter int BUF_DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         arrive_i,
  input  logic                         head_i,
  input  logic                         tail_i,
  input  logic                         route_i,
  input  logic [$clog2(NUM_PORTS)-1:0] route_port_i,
  input  logic                         vagnt_i,
  input  logic [$clog2(NUM_VC)-1:0]    vagnt_ovc_i,
  input  logic                         pop_i,
  input  logic                         cred_cur_nz_i,
  input  logic                         cred_nxt_nz_i,
  output ivc_state_e                   state_o,
  output logic [$clog2(NUM_PORTS)-1:0] port_o,
  output logic [$clog2(NUM_VC)-1:0]    ovc_o,
  output logic                         req_o,
  output logic                         front_tail_o,
  output logic                         empty_o
);
  localparam int PW = $clog2(NUM_PORTS);
  localparam int VW = $clog2(NUM_VC);
  localparam int AW = $clog2(BUF_DEPTH);

  ivc_state_e      state_q, state_d;
  logic [PW-1:0]   port_q;
  logic [VW-1:0]   ovc_q;
  logic [AW-1:0]   rd_q, wr_q;
  logic [AW:0]     cnt_q, cnt_d;
  logic [BUF_DEPTH-1:0] tail_mem_q;
  logic            push, release_pkt;

  assign push         = arrive_i && (cnt_q != (AW+1)'(BUF_DEPTH));
  assign cnt_d        = cnt_q + {{AW{1'b0}}, push} - {{AW{1'b0}}, pop_i};
  assign front_tail_o = tail_mem_q[rd_q];
  assign empty_o      = (cnt_q == '0);
  assign release_pkt  = pop_i && front_tail_o;
  assign req_o        = (state_q == IVC_ACTIVE) && !empty_o && cred_cur_nz_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      IVC_IDLE:    if (arrive_i && head_i) state_d = IVC_ROUTE;
      IVC_ROUTE:   if (route_i) state_d = IVC_WAIT_VC;
      IVC_WAIT_VC: if (vagnt_i) state_d = cred_nxt_nz_i ? IVC_ACTIVE : IVC_WAIT_CRED;
      IVC_ACTIVE, IVC_WAIT_CRED: begin
        if (release_pkt) state_d = (cnt_d != '0) ? IVC_ROUTE : IVC_IDLE;
        else             state_d = cred_nxt_nz_i ? IVC_ACTIVE : IVC_WAIT_CRED;
      end
      default: state_d = IVC_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= IVC_IDLE;
      port_q     <= '0;
      ovc_q      <= '0;
      rd_q       <= '0;
      wr_q       <= '0;
      cnt_q      <= '0;
      tail_mem_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (push) begin
        tail_mem_q[wr_q] <= tail_i;
        wr_q             <= wr_q + 1'b1;
      end
      if (pop_i) rd_q <= rd_q + 1'b1;
      if (route_i && state_q == IVC_ROUTE) port_q <= route_port_i;
      if (vagnt_i && state_q == IVC_WAIT_VC) ovc_q <= vagnt_ovc_i;
      if (release_pkt) begin
        port_q <= '0;
        ovc_q  <= '0;
      end
    end
  end

  assign state_o = state_q;
  assign port_o  = port_q;
  assign ovc_o   = ovc_q;

  // R5: a grant without a new arrival drains exactly one cell
  a_r5_pop_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !arrive_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R11: last flit being a tail sends the VC to idle
  a_r11_tail_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && front_tail_o && !arrive_i && cnt_q == 1) |=> (state_q == IVC_IDLE));
endmodule

// File: rtl/vc_out_unit.sv
module vc_out_unit
  import vc_ctrl_pkg::*;
#(
  parameter int NUM_VC   = 4,
  parameter int CRED_MAX = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            alloc_i,
  input  logic [$clog2(NUM_VC)-1:0]       owner_i,
  input  logic                            release_i,
  input  logic                            dec_i,
  input  logic                            inc_i,
  output ovc_state_e                      state_o,
  output logic [$clog2(NUM_VC)-1:0]       owner_o,
  output logic [$clog2(CRED_MAX+1)-1:0]   cred_o,
  output logic                            cred_nxt_nz_o,
  output logic                            err_o
);
  localparam int VW = $clog2(NUM_VC);
  localparam int CW = $clog2(CRED_MAX + 1);

  ovc_state_e    state_q, state_d;
  logic [VW-1:0] owner_q;
  logic [CW-1:0] cred_q, cred_d;

  always_comb begin
    cred_d = cred_q;
    err_o  = 1'b0;
    if (inc_i && !dec_i) begin
      if (cred_q == CW'(CRED_MAX)) err_o = 1'b1;
      else                         cred_d = cred_q + 1'b1;
    end else if (dec_i && !inc_i) begin
      cred_d = cred_q - 1'b1;
    end
  end

  assign cred_nxt_nz_o = (cred_d != '0);

  always_comb begin
    state_d = state_q;
    if (release_i)                         state_d = OVC_IDLE;
    else if (alloc_i || state_q != OVC_IDLE) state_d = cred_nxt_nz_o ? OVC_ACTIVE : OVC_WAIT_CRED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= OVC_IDLE;
      owner_q <= '0;
      cred_q  <= CW'(CRED_MAX);
    end else begin
      state_q <= state_d;
      cred_q  <= cred_d;
      if (alloc_i)        owner_q <= owner_i;
      else if (release_i) owner_q <= '0;
    end
  end

  assign state_o = state_q;
  assign owner_o = owner_q;
  assign cred_o  = cred_q;

  // R7: an owned VC parks only when it holds no credit
  a_r7_wait_means_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OVC_WAIT_CRED) |-> (cred_q == '0));

  // R10: coincident spend and return cancel
  a_r10_both_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> (cred_q == $past(cred_q)));

  // R8: count moves by at most one per cycle
  a_r8_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cred_q != $past(cred_q)) |->
      (cred_q == $past(cred_q) + 1'b1 || cred_q == $past(cred_q) - 1'b1));
endmodule

// File: rtl/vc_credit_ctrl.sv
module vc_credit_ctrl
  import vc_ctrl_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int NUM_PORTS = 5,
  parameter int BUF_DEPTH = 8,
  parameter int CRED_MAX  = 8,
  localparam int VW = $clog2(NUM_VC),
  localparam int PW = $clog2(NUM_PORTS),
  localparam int CW = $clog2(CRED_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flit_valid_i,
  input  logic [VW-1:0]        flit_vc_i,
  input  logic                 flit_head_i,
  input  logic                 flit_tail_i,
  input  logic                 route_valid_i,
  input  logic [VW-1:0]        route_vc_i,
  input  logic [PW-1:0]        route_port_i,
  input  logic                 va_valid_i,
  input  logic [VW-1:0]        va_ivc_i,
  input  logic [VW-1:0]        va_ovc_i,
  input  logic [NUM_VC-1:0]    sw_gnt_i,
  input  logic [1:0]           cred_in_type_i,
  input  logic [VW-1:0]        cred_in_vc_i,
  output logic [NUM_VC-1:0]    sw_req_o,
  output logic [1:0]           cred_out_type_o,
  output logic [VW-1:0]        cred_out_vc_o,
  output logic [NUM_VC*3-1:0]  ivc_state_o,
  output logic [NUM_VC*PW-1:0] ivc_port_o,
  output logic [NUM_VC*VW-1:0] ivc_ovc_o,
  output logic [NUM_VC*2-1:0]  ovc_state_o,
  output logic [NUM_VC*VW-1:0] ovc_owner_o,
  output logic [NUM_VC*CW-1:0] ovc_cred_o,
  output logic [NUM_VC-1:0]    stall_busy_o,
  output logic [NUM_VC-1:0]    stall_route_o,
  output logic [NUM_VC-1:0]    stall_va_o,
  output logic [NUM_VC-1:0]    stall_sw_o,
  output logic [NUM_VC-1:0]    stall_empty_o,
  output logic [NUM_VC-1:0]    stall_cred_o,
  output logic                 cred_err_o
);
  ivc_state_e    ivc_st    [NUM_VC];
  logic [VW-1:0] ivc_ovc   [NUM_VC];
  ovc_state_e    ovc_st    [NUM_VC];
  logic [VW-1:0] ovc_owner [NUM_VC];
  logic [CW-1:0] ovc_cred  [NUM_VC];

  logic [NUM_VC-1:0] front_tail, empty, gnt_eff, ovc_nz_nxt, ovc_err;
  logic [NUM_VC-1:0] dec, rel;
  logic              va_ok;
  logic [VW-1:0]     gvc;

  assign va_ok   = va_valid_i && ivc_st[va_ivc_i] == IVC_WAIT_VC && ovc_st[va_ovc_i] == OVC_IDLE;
  assign gnt_eff = sw_gnt_i & sw_req_o;

  always_comb begin
    dec = '0;
    rel = '0;
    for (int o = 0; o < NUM_VC; o++)
      for (int v = 0; v < NUM_VC; v++)
        if (gnt_eff[v] && ivc_ovc[v] == VW'(o)) begin
          dec[o] = 1'b1;
          if (front_tail[v]) rel[o] = 1'b1;
        end
  end

  always_comb begin
    gvc = '0;
    for (int v = NUM_VC - 1; v >= 0; v--)
      if (gnt_eff[v]) gvc = VW'(v);
  end

  for (genvar v = 0; v < NUM_VC; v++) begin : g_ivc
    logic [VW-1:0] sel;
    logic [PW-1:0] port;
    logic          hit;
    assign sel = (ivc_st[v] == IVC_WAIT_VC) ? va_ovc_i : ivc_ovc[v];
    assign hit = flit_valid_i && flit_vc_i == VW'(v);

    vc_in_unit #(.NUM_VC(NUM_VC), .NUM_PORTS(NUM_PORTS), .BUF_DEPTH(BUF_DEPTH)) i_in (
      .clk_i, .rst_ni,
      .arrive_i     (hit),
      .head_i       (flit_head_i),
      .tail_i       (flit_tail_i),
      .route_i      (route_valid_i && route_vc_i == VW'(v)),
      .route_port_i (route_port_i),
      .vagnt_i      (va_ok && va_ivc_i == VW'(v)),
      .vagnt_ovc_i  (va_ovc_i),
      .pop_i        (gnt_eff[v]),
      .cred_cur_nz_i(ovc_cred[ivc_ovc[v]] != '0),
      .cred_nxt_nz_i(ovc_nz_nxt[sel]),
      .state_o      (ivc_st[v]),
      .port_o       (port),
      .ovc_o        (ivc_ovc[v]),
      .req_o        (sw_req_o[v]),
      .front_tail_o (front_tail[v]),
      .empty_o      (empty[v])
    );

    assign ivc_state_o[v*3 +: 3]  = ivc_st[v];
    assign ivc_port_o[v*PW +: PW] = port;
    assign ivc_ovc_o[v*VW +: VW]  = ivc_ovc[v];
    assign stall_busy_o[v]  = hit && flit_head_i && ivc_st[v] != IVC_IDLE;
    assign stall_route_o[v] = ivc_st[v] == IVC_ROUTE;
    assign stall_va_o[v]    = ivc_st[v] == IVC_WAIT_VC;
    assign stall_sw_o[v]    = sw_req_o[v] && !sw_gnt_i[v];
    assign stall_empty_o[v] = ivc_st[v] == IVC_ACTIVE && empty[v];
    assign stall_cred_o[v]  = ivc_st[v] == IVC_WAIT_CRED;
  end

  for (genvar o = 0; o < NUM_VC; o++) begin : g_ovc
    vc_out_unit #(.NUM_VC(NUM_VC), .CRED_MAX(CRED_MAX)) i_out (
      .clk_i, .rst_ni,
      .alloc_i      (va_ok && va_ovc_i == VW'(o)),
      .owner_i      (va_ivc_i),
      .release_i    (rel[o]),
      .dec_i        (dec[o]),
      .inc_i        (cred_in_type_i == LINK_CREDIT && cred_in_vc_i == VW'(o)),
      .state_o      (ovc_st[o]),
      .owner_o      (ovc_owner[o]),
      .cred_o       (ovc_cred[o]),
      .cred_nxt_nz_o(ovc_nz_nxt[o]),
      .err_o        (ovc_err[o])
    );

    assign ovc_state_o[o*2 +: 2]  = ovc_st[o];
    assign ovc_owner_o[o*VW +: VW] = ovc_owner[o];
    assign ovc_cred_o[o*CW +: CW]  = ovc_cred[o];

    // R4: an owned output VC points back at an input VC that points at it
    a_r4_owner_agrees: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovc_st[o] != OVC_IDLE) |->
        (ivc_ovc[ovc_owner[o]] == VW'(o) &&
         (ivc_st[ovc_owner[o]] == IVC_ACTIVE || ivc_st[ovc_owner[o]] == IVC_WAIT_CRED)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_out_type_o <= LINK_IDLE;
      cred_out_vc_o   <= '0;
      cred_err_o      <= 1'b0;
    end else begin
      cred_out_type_o <= (|gnt_eff) ? LINK_CREDIT : LINK_IDLE;
      cred_out_vc_o   <= gvc;
      cred_err_o      <= |ovc_err;
    end
  end

  // R6: every switch grant is answered by an upstream credit next cycle
  a_r6_credit_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_eff) |=> (cred_out_type_o == LINK_CREDIT));

  // R5: requests only from VCs with buffered flits
  a_r5_req_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(sw_req_o & empty)) == 1'b0);
endmodule

// File: tb/test_vc_credit_ctrl.sv
`timescale 1ns/1ps
module test_vc_credit_ctrl;
  localparam int NV = 2, NP = 4, BD = 4, CM = 3;
  localparam int VW = 1, PW = 2, CW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          flit_valid, flit_head, flit_tail;
  logic [VW-1:0] flit_vc;
  logic          route_valid;
  logic [VW-1:0] route_vc;
  logic [PW-1:0] route_port;
  logic          va_valid;
  logic [VW-1:0] va_ivc, va_ovc;
  logic [NV-1:0] sw_gnt;
  logic [1:0]    cin_type;
  logic [VW-1:0] cin_vc;
  logic [NV-1:0] sw_req;
  logic [1:0]    cout_type;
  logic [VW-1:0] cout_vc;
  logic [NV*3-1:0]  ivc_state;
  logic [NV*PW-1:0] ivc_port;
  logic [NV*VW-1:0] ivc_ovc;
  logic [NV*2-1:0]  ovc_state;
  logic [NV*VW-1:0] ovc_owner;
  logic [NV*CW-1:0] ovc_cred;
  logic [NV-1:0] st_busy, st_route, st_va, st_sw, st_empty, st_cred;
  logic          cerr;

  vc_credit_ctrl #(.NUM_VC(NV), .NUM_PORTS(NP), .BUF_DEPTH(BD), .CRED_MAX(CM)) i_vc_credit_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .flit_valid_i(flit_valid), .flit_vc_i(flit_vc), .flit_head_i(flit_head), .flit_tail_i(flit_tail),
    .route_valid_i(route_valid), .route_vc_i(route_vc), .route_port_i(route_port),
    .va_valid_i(va_valid), .va_ivc_i(va_ivc), .va_ovc_i(va_ovc),
    .sw_gnt_i(sw_gnt), .cred_in_type_i(cin_type), .cred_in_vc_i(cin_vc),
    .sw_req_o(sw_req), .cred_out_type_o(cout_type), .cred_out_vc_o(cout_vc),
    .ivc_state_o(ivc_state), .ivc_port_o(ivc_port), .ivc_ovc_o(ivc_ovc),
    .ovc_state_o(ovc_state), .ovc_owner_o(ovc_owner), .ovc_cred_o(ovc_cred),
    .stall_busy_o(st_busy), .stall_route_o(st_route), .stall_va_o(st_va),
    .stall_sw_o(st_sw), .stall_empty_o(st_empty), .stall_cred_o(st_cred),
    .cred_err_o(cerr)
  );

  int n_chk = 0, n_bad = 0;
  int exp_cred [NV];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ist(int v);   return int'(ivc_state[v*3 +: 3]);   endfunction
  function automatic int iport(int v); return int'(ivc_port[v*PW +: PW]); endfunction
  function automatic int iovc(int v);  return int'(ivc_ovc[v*VW +: VW]);  endfunction
  function automatic int ost(int o);   return int'(ovc_state[o*2 +: 2]);   endfunction
  function automatic int oown(int o);  return int'(ovc_owner[o*VW +: VW]); endfunction
  function automatic int ocr(int o);   return int'(ovc_cred[o*CW +: CW]);  endfunction

  task automatic clear_in();
    flit_valid = 0; flit_head = 0; flit_tail = 0; flit_vc = '0;
    route_valid = 0; route_vc = '0; route_port = '0;
    va_valid = 0; va_ivc = '0; va_ovc = '0;
    sw_gnt = '0; cin_type = 2'b00; cin_vc = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic arrive(int v, bit h, bit t);
    flit_valid = 1; flit_vc = VW'(v); flit_head = h; flit_tail = t;
    tick(); clear_in();
  endtask

  task automatic route(int v, int p);
    route_valid = 1; route_vc = VW'(v); route_port = PW'(p);
    tick(); clear_in();
  endtask

  task automatic vagrant(int v, int o);
    va_valid = 1; va_ivc = VW'(v); va_ovc = VW'(o);
    tick(); clear_in();
  endtask

  task automatic credit(logic [1:0] ty, int o);
    cin_type = ty; cin_vc = VW'(o);
    tick(); clear_in();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_in();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();

    // R1 reset state
    for (int v = 0; v < NV; v++) begin
      chk("R1 ivc state", ist(v), 0);
      chk("R1 ovc state", ost(v), 0);
      chk("R1 credit", ocr(v), CM);
      exp_cred[v] = CM;
    end
    chk("R1 req", int'(sw_req), 0);
    chk("R1 cout", int'(cout_type), 0);
    chk("R1 err", int'(cerr), 0);

    // packet sweep: lengths 1..CM+1
    for (int len = 1; len <= CM + 1; len++) begin
      int v = len % 2;
      int o = 1 - v;
      arrive(v, 1'b1, len == 1);
      chk("R2 head to routing", ist(v), 1);
      chk("R3 route stall", int'(st_route[v]), 1);
      route(v, len % NP);
      chk("R3 wait vc", ist(v), 2);
      chk("R3 port", iport(v), len % NP);
      chk("R4 va stall", int'(st_va[v]), 1);
      vagrant(v, o);
      chk("R4 active", ist(v), 3);
      chk("R4 ovc active", ost(o), 1);
      chk("R4 owner", oown(o), v);
      chk("R4 assigned", iovc(v), o);
      for (int i = 0; i < len; i++) begin
        if (i > 0) begin
          if (exp_cred[o] != 0) begin
            chk("R5 empty stall", int'(st_empty[v]), 1);
            chk("R5 no req empty", int'(sw_req[v]), 0);
          end
          arrive(v, 1'b0, i == len - 1);
        end
        if (exp_cred[o] == 0) begin
          chk("R7 ivc wait cred", ist(v), 4);
          chk("R7 ovc wait cred", ost(o), 2);
          chk("R7 cred stall", int'(st_cred[v]), 1);
          chk("R7 no req", int'(sw_req[v]), 0);
          credit(2'b10, o);
          exp_cred[o]++;
          chk("R8 increment", ocr(o), exp_cred[o]);
          chk("R7 resume", ist(v), 3);
        end
        chk("R5 req", int'(sw_req[v]), 1);
        sw_gnt[v] = 1'b1;
        tick(); clear_in();
        exp_cred[o]--;
        chk("R6 decrement", ocr(o), exp_cred[o]);
        chk("R6 cout type", int'(cout_type), 2);
        chk("R6 cout vc", int'(cout_vc), v);
      end
      chk("R11 ivc idle", ist(v), 0);
      chk("R11 ovc idle", ost(o), 0);
      chk("R11 port cleared", iport(v), 0);
      chk("R11 owner cleared", oown(o), 0);
      chk("R11 credit kept", ocr(o), exp_cred[o]);
      while (exp_cred[o] < CM) begin
        credit(2'b10, o);
        exp_cred[o]++;
        chk("R8 refill", ocr(o), exp_cred[o]);
      end
    end

    // directed corners
    arrive(1, 1'b1, 1'b1);
    route(1, 2);
    vagrant(1, 1);
    chk("R4 active vc1", ist(1), 3);
    route(1, 3);
    chk("R3 route ignored", iport(1), 2);
    chk("R3 state kept", ist(1), 3);
    credit(2'b11, 1);
    chk("R8 flit type ignored", ocr(1), CM);
    chk("R8 flit type no err", int'(cerr), 0);
    credit(2'b00, 1);
    chk("R8 idle type ignored", ocr(1), CM);
    credit(2'b01, 1);
    chk("R8 idle type 01 ignored", ocr(1), CM);
    credit(2'b10, 1);
    chk("R9 err pulse", int'(cerr), 1);
    chk("R9 saturate", ocr(1), CM);
    tick();
    chk("R9 err one cycle", int'(cerr), 0);
    #1;
    chk("R5 req no grant", int'(sw_req[1]), 1);
    chk("R5 switch stall", int'(st_sw[1]), 1);
    flit_valid = 1; flit_vc = 1'b1; flit_head = 1; flit_tail = 1;
    #1;
    chk("R2 busy stall", int'(st_busy[1]), 1);
    tick(); clear_in();
    chk("R2 busy keeps state", ist(1), 3);

    arrive(0, 1'b1, 1'b1);
    route(0, 1);
    vagrant(0, 1);
    chk("R4 owned ovc refused", ist(0), 2);
    chk("R4 va stall held", int'(st_va[0]), 1);
    chk("R4 owner unchanged", oown(1), 1);

    sw_gnt = 2'b10; cin_type = 2'b10; cin_vc = 1'b1;
    tick(); clear_in();
    chk("R10 at cap unchanged", ocr(1), CM);
    chk("R10 no err", int'(cerr), 0);
    chk("R6 cout vc1", int'(cout_vc), 1);
    chk("R11 waiting head to routing", ist(1), 1);
    chk("R11 ovc released", ost(1), 0);

    vagrant(0, 1);
    chk("R4 late grant", ist(0), 3);
    chk("R4 new owner", oown(1), 0);
    sw_gnt = 2'b01;
    tick(); clear_in();
    chk("R6 spend", ocr(1), CM - 1);
    chk("R11 vc0 idle", ist(0), 0);

    route(1, 0);
    vagrant(1, 1);
    chk("R4 vc1 regrant", ist(1), 3);
    sw_gnt = 2'b10; cin_type = 2'b10; cin_vc = 1'b1;
    tick(); clear_in();
    chk("R10 below cap unchanged", ocr(1), CM - 1);
    credit(2'b10, 1);
    chk("R8 restore", ocr(1), CM);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule